// File: doc/BRIEF.md
# Double-Edge Strobed Burst Data Link

This block is the data path of a 16-bit source-synchronous burst link. Whichever side drives the data words also drives the strobe, and every strobe transition carries one word, so the strobe toggles at most once per word. In send mode the block puts a word on the bus and holds it for a programmable number of system clock cycles. That interval covers propagation, cable settling and setup. Only then does the block toggle the strobe.

In receive mode the block brings the incoming strobe into the system clock domain through two flops, together with the data. It captures one word on each detected transition, rising or falling, into a four-entry buffer that the consumer drains.

Burst behaviour applies only while three inputs are all high: burst mode selected, a DMA read or write command pending, and acknowledge asserted. When acknowledge drops, the bus is released and the strobe returns to its idle high level. The first transfer edge after idle is therefore always a falling edge. The direction input chooses the role: it is high when this side owns the bus (outbound) and low when the far side sends (inbound).

Top module: `dstrobe_link`

## Requirements
- R1: `burst_active` is high exactly while `mode_sel`, `cmd_pend` and `ack` are all high.
- R2: After reset `stb_o` is 1, and `dq_oe`, `tx_ready` and `rx_valid` are 0.
- R3: `dq_oe` is 1 only while the burst is active and `tx_dir` is 1 (send). It is 0 in receive.
- R4: A word accepted on a clock edge (`tx_valid` and `tx_ready`) appears on `dq_o` after that edge. The strobe toggles exactly S edges after acceptance, with `dq_o` unchanged until the toggle.
- R5: Each strobe toggle carries one word, and successive words alternate falling and rising edges. The first word after idle uses a falling edge (1 to 0).
- R6: S equals `settle`, except that values 0 and 1 are treated as 2.
- R7: `tx_ready` is 1 only while sending is active and no word waits for its strobe. It returns to 1 in the cycle after the toggle.
- R8: In receive, every transition of `stb_i`, either direction, captures the `dq_i` word. `rx_valid` rises after the third clock edge following the transition, and words leave the buffer in arrival order.
- R9: The buffer holds 4 words. A word arriving while the buffer is full is dropped, and the stored words are kept.
- R10: While the burst is inactive, `stb_o` returns to 1, any word waiting for its strobe is abandoned, and strobe transitions on `stb_i` capture nothing.
- R11: `rx_pop` while `rx_valid` is 1 removes the head word on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | Burst mode selected |
| cmd_pend | input | 1 | DMA read/write command pending |
| ack | input | 1 | Acknowledge asserted (active high) |
| tx_dir | input | 1 | 1: this side sends, 0: this side receives |
| settle | input | SETW | Settle interval in clock cycles (minimum 2) |
| tx_valid | input | 1 | Word offered for sending |
| tx_data | input | W | Word to send |
| tx_ready | output | 1 | Block accepts a word this cycle |
| dq_o | output | W | Bus data driven out |
| dq_oe | output | 1 | Bus drive enable |
| stb_o | output | 1 | Strobe driven out |
| dq_i | input | W | Bus data in |
| stb_i | input | 1 | Strobe in from the far side |
| rx_valid | output | 1 | Buffer holds at least one word |
| rx_data | output | W | Head word of the buffer |
| rx_pop | input | 1 | Remove head word |
| burst_active | output | 1 | All three burst conditions hold |

## Verification
The bench builds the block with its defaults: 16-bit words, an 8-bit settle field and a 4-deep buffer. With the 8-bit field, settle values from 0 to 9 can be applied, so both clamped values and several unclamped intervals are measured edge by edge. The 4-deep buffer is filled by four transitions, so a fifth transition reaches the overflow drop and the in-order drain. Acknowledge is dropped once in the middle of a settle wait and once during a receive, which exercises the abandon and ignore paths.

// File: rtl/dstrobe_link.sv
module dstrobe_link #(
  parameter int W     = 16,
  parameter int SETW  = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_sel,
  input  logic            cmd_pend,
  input  logic            ack,
  input  logic            tx_dir,
  input  logic [SETW-1:0] settle,
  input  logic            tx_valid,
  input  logic [W-1:0]    tx_data,
  output logic            tx_ready,
  output logic [W-1:0]    dq_o,
  output logic            dq_oe,
  output logic            stb_o,
  input  logic [W-1:0]    dq_i,
  input  logic            stb_i,
  output logic            rx_valid,
  output logic [W-1:0]    rx_data,
  input  logic            rx_pop,
  output logic            burst_active
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic            send_en, rx_en;
  logic            busy;
  logic [SETW-1:0] cnt, s_eff;
  logic [W-1:0]    dq_q;
  logic            stb_q;

  assign burst_active = mode_sel & cmd_pend & ack;
  assign send_en      = burst_active & tx_dir;
  assign rx_en        = burst_active & ~tx_dir;
  assign s_eff        = (settle < SETW'(2)) ? SETW'(2) : settle;
  assign tx_ready     = send_en & ~busy;
  assign dq_o         = dq_q;
  assign dq_oe        = send_en;
  assign stb_o        = stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      dq_q  <= '0;
      stb_q <= 1'b1;
    end else if (!send_en) begin
      busy  <= 1'b0;
      stb_q <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) begin
        stb_q <= ~stb_q;
        busy  <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (tx_valid) begin
      dq_q <= tx_data;
      cnt  <= s_eff - 1'b1;
      busy <= 1'b1;
    end
  end

  logic         s1, s2, s3;
  logic [W-1:0] d1, d2;
  logic         edge_seen, push, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      d1 <= '0;   d2 <= '0;
    end else begin
      s1 <= stb_i; s2 <= s1; s3 <= s2;
      d1 <= dq_i;  d2 <= d1;
    end
  end

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] fill;

  assign edge_seen = s2 ^ s3;
  assign push      = rx_en & edge_seen & (fill != CW'(DEPTH));
  assign pop       = rx_pop & (fill != '0);
  assign rx_valid  = (fill != '0);
  assign rx_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= d2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      fill <= fill + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/dstrobe_link_chk.sv
module dstrobe_link_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          burst_active,
  input logic          tx_dir,
  input logic          tx_ready,
  input logic          stb_o,
  input logic [W-1:0]  dq_o,
  input logic          dq_oe,
  input logic [CW-1:0] fill
);
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |=> stb_o);

  a_r3_no_drive_rx: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dir |-> !dq_oe);

  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && $past(burst_active) && !$stable(stb_o)) |-> $stable(dq_o));

  a_r7_ready_send: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (burst_active && tx_dir));

  a_r5_one_per_word: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !$stable(stb_o)) |=> (!burst_active || $stable(stb_o)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
endmodule

bind dstrobe_link dstrobe_link_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_active(burst_active), .tx_dir(tx_dir),
  .tx_ready(tx_ready), .stb_o(stb_o), .dq_o(dq_o), .dq_oe(dq_oe), .fill(fill)
);

// File: tb/sim_dstrobe_link.sv
`timescale 1ns/1ps
module sim_dstrobe_link;
  logic        clk = 0, rst_n = 0;
  logic        mode_sel = 0, cmd_pend = 0, ack = 0, tx_dir = 1;
  logic [7:0]  settle = 2;
  logic        tx_valid = 0;
  logic [15:0] tx_data = 0;
  logic        tx_ready, dq_oe, stb_o, rx_valid, burst_active;
  logic [15:0] dq_o, rx_data;
  logic [15:0] dq_i = 0;
  logic        stb_i = 1, rx_pop = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dstrobe_link u0 (.*);

  localparam int          NV = 6;
  localparam int          SET_V [NV] = '{0, 1, 2, 3, 5, 9};
  localparam int          EXP_S [NV] = '{2, 2, 2, 3, 5, 9};
  localparam logic [15:0] DAT_V [NV] = '{16'h1234, 16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'h8001};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input int st, input logic [15:0] d, input int exp_s, input logic exp_lvl);
    logic prev;
    int n;
    @(negedge clk);
    settle = st[7:0]; tx_data = d; tx_valid = 1;
    prev = stb_o;
    @(posedge clk); @(negedge clk);
    tx_valid = 0;
    chk(dq_o == d, "R4 data on bus", dq_o, d);
    chk(tx_ready == 0, "R7 busy while waiting", tx_ready, 0);
    n = 0;
    while (stb_o == prev && n < 40) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == exp_s, "R6 R4 settle edges", n, exp_s);
    chk(stb_o == exp_lvl, "R5 strobe edge level", stb_o, exp_lvl);
    chk(dq_o == d, "R4 data held at toggle", dq_o, d);
    chk(tx_ready == 1, "R7 ready after toggle", tx_ready, 1);
  endtask

  task automatic rx_word(input logic [15:0] d);
    @(negedge clk);
    dq_i = d; stb_i = ~stb_i;
    repeat (4) @(posedge clk);
  endtask

  task automatic pop_chk(input logic [15:0] d);
    @(negedge clk);
    chk(rx_valid == 1, "R11 word present", rx_valid, 1);
    chk(rx_data == d, "R8 R11 order", rx_data, d);
    rx_pop = 1;
    @(posedge clk); @(negedge clk);
    rx_pop = 0;
  endtask

  initial begin
    logic lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(stb_o == 1, "R2 strobe idle", stb_o, 1);
    chk(dq_oe == 0, "R2 no drive", dq_oe, 0);
    chk(tx_ready == 0, "R2 not ready", tx_ready, 0);
    chk(rx_valid == 0, "R2 empty", rx_valid, 0);
    rst_n = 1;
    @(negedge clk);
    mode_sel = 1; cmd_pend = 1; #1;
    chk(burst_active == 0, "R1 ack low", burst_active, 0);
    ack = 1; #1;
    chk(burst_active == 1, "R1 all high", burst_active, 1);
    cmd_pend = 0; #1;
    chk(burst_active == 0, "R1 no command", burst_active, 0);
    cmd_pend = 1; #1;
    chk(dq_oe == 1, "R3 drive in send", dq_oe, 1);
    chk(tx_ready == 1, "R7 ready idle", tx_ready, 1);

    lvl = 1;
    for (int i = 0; i < NV; i++) begin
      lvl = ~lvl;
      send(SET_V[i], DAT_V[i], EXP_S[i], lvl);
    end
    send(2, 16'h7777, 2, 1'b0);
    chk(stb_o == 0, "R5 strobe low before abandon", stb_o, 0);

    @(negedge clk);
    settle = 20; tx_data = 16'hDEAD; tx_valid = 1;
    @(posedge clk); @(negedge clk);
    tx_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); ack = 0;
    @(posedge clk); @(negedge clk);
    chk(stb_o == 1, "R10 strobe back high", stb_o, 1);
    chk(dq_oe == 0, "R10 R3 released", dq_oe, 0);
    chk(tx_ready == 0, "R10 not ready", tx_ready, 0);
    ack = 1;
    repeat (25) @(posedge clk);
    @(negedge clk);
    chk(stb_o == 1, "R10 abandoned word sent no edge", stb_o, 1);
    chk(tx_ready == 1, "R10 ready after reactivation", tx_ready, 1);
    send(4, 16'hBEEF, 4, 1'b0);

    @(negedge clk);
    tx_dir = 0; #1;
    chk(dq_oe == 0, "R3 no drive in receive", dq_oe, 0);
    chk(tx_ready == 0, "R7 not ready in receive", tx_ready, 0);
    @(negedge clk);
    dq_i = 16'hA001; stb_i = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rx_valid == 0, "R8 not yet after two edges", rx_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(rx_valid == 1, "R8 valid after three edges", rx_valid, 1);
    chk(rx_data == 16'hA001, "R8 falling edge word", rx_data, 16'hA001);
    repeat (2) @(posedge clk);
    rx_word(16'hA002);
    rx_word(16'hA003);
    rx_word(16'hA004);
    rx_word(16'hA005);
    pop_chk(16'hA001);
    pop_chk(16'hA002);
    pop_chk(16'hA003);
    pop_chk(16'hA004);
    @(negedge clk);
    chk(rx_valid == 0, "R9 fifth word dropped", rx_valid, 0);

    @(negedge clk); ack = 0;
    rx_word(16'hC001);
    rx_word(16'hC002);
    @(negedge clk);
    chk(rx_valid == 0, "R10 no capture inactive", rx_valid, 0);
    ack = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(rx_valid == 0, "R10 none after reactivation", rx_valid, 0);
    rx_word(16'hC003);
    pop_chk(16'hC003);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule